// File: doc/BRIEF.md
# Sequential Integer Square Root Unit

This unit takes an unsigned operand of `DATA_W` bits and returns its integer square root (`DATA_W/2` bits) together with the remainder (`DATA_W/2 + 1` bits), so that root squared plus remainder equals the operand. It is built for area rather than throughput. One adder/subtractor is reused on every cycle, and three shift registers hold the operand, the partial root and the partial remainder. One root bit is settled per clock.

The work is non-restoring. A partial remainder that goes negative is kept and carried into the next step. The sign of that remainder sets the operation. A non-negative remainder subtracts the partial root with binary 01 appended. A negative remainder adds the partial root with binary 11 appended. After the last root bit, a single extra cycle corrects a negative remainder by adding twice the root plus one, on the same adder.

Operands enter through a valid/ready pair. An operand is taken on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low from that edge until the result appears, which is how the unit applies back-pressure. An operand offered while `in_ready` is low is not taken. The result side has no back-pressure. `out_valid` is a one-cycle pulse, and `out_root` and `out_rem` then hold their values until the next operand is taken.

Top module: `nrsqrt_unit`

## Requirements
- R1: `in_ready` is high whenever no operation is in progress. It falls on the edge that takes an operand. While it is low, `in_valid` and `in_operand` have no effect on the result being computed.
- R2: After an operand is taken on edge E, `out_valid` is high for exactly one cycle, following edge E+17. That is 16 iteration cycles and one correction cycle.
- R3: `out_root` equals floor(sqrt(operand)) for every operand value, 0 and 2^DATA_W-1 included.
- R4: `out_rem` equals operand minus `out_root` squared, and never exceeds 2 × `out_root`.
- R5: Outside an operation, `out_root` and `out_rem` keep their last values until the next operand is taken.
- R6: Each iteration shifts the operand left by two bits and feeds its top two bits into the low end of the remainder shifted left by two. If the previous remainder is non-negative it subtracts {root, 0, 1}; otherwise it adds {root, 1, 1}. The new root bit, entering at the root's LSB, is 1 exactly when the new remainder is non-negative.
- R7: If the remainder after the last iteration is negative, 2 × root + 1 is added to it, so the reported remainder is never negative.
- R8: During and right after reset, `in_ready` is 1, `out_valid` is 0, and `out_root` and `out_rem` are 0.
- R9: `in_ready` is already high in the cycle where `out_valid` is high, so operands can be taken back to back, one every 18 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operand is offered |
| in_ready | output | 1 | The unit is idle and will take an operand |
| in_operand | input | DATA_W | Unsigned operand |
| out_valid | output | 1 | One-cycle pulse: the result is valid |
| out_root | output | DATA_W/2 | Integer square root |
| out_rem | output | DATA_W/2+1 | Remainder, operand minus root squared |

## Verification
The bench uses the default `DATA_W` of 32, so the datapath is the full 18-bit remainder path.

This width makes the largest operand, 2^32-1, reachable. That operand gives the widest remainder, 131070, which tests the top remainder bit and the modular wrap of the shifted remainder.

Directed operands cover exact squares, squares minus one and very small values, which exercise the correction step and the last-bit decision. Random operands fill in the rest. Offers made while the unit is busy, and operands sent back to back, exercise the handshake timing.

// File: rtl/nrsqrt_pkg.sv
package nrsqrt_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ITER = 2'd1,
    SQ_FIX  = 2'd2
  } sq_state_e;

endpackage

// File: rtl/nrsqrt_addsub.sv
module nrsqrt_addsub #(
  parameter int W = 18
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum
);
  // One two's-complement adder. Subtraction is a plus the inverted b plus 1.
  logic [W-1:0] b_eff;
  always_comb begin
    b_eff = sub ? ~b : b;
    sum   = a + b_eff + {{(W-1){1'b0}}, sub};
  end
endmodule

// File: rtl/nrsqrt_ctrl.sv
module nrsqrt_ctrl
  import nrsqrt_pkg::*;
#(
  parameter int ROOT_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  output logic load,
  output logic step,
  output logic fix,
  output logic out_valid
);
  localparam int CNT_W = (ROOT_W > 1) ? $clog2(ROOT_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ROOT_W - 1);

  sq_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    in_ready = (state_q == SQ_IDLE);
    load     = in_ready && in_valid;
    step     = (state_q == SQ_ITER);
    fix      = (state_q == SQ_FIX);
    state_d  = state_q;
    unique case (state_q)
      SQ_IDLE: if (in_valid)        state_d = SQ_ITER;
      SQ_ITER: if (cnt_q == LAST)   state_d = SQ_FIX;
      SQ_FIX:                       state_d = SQ_IDLE;
      default:                      state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SQ_IDLE;
      cnt_q     <= '0;
      out_valid <= 1'b0;
    end else begin
      state_q   <= state_d;
      out_valid <= fix;
      if (load)      cnt_q <= '0;
      else if (step) cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_take_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !in_ready);

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_fix_then_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fix |=> (out_valid && in_ready));

  assert_no_step_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !(step || fix));
endmodule

// File: rtl/nrsqrt_path.sv
module nrsqrt_path #(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                step,
  input  logic                fix,
  input  logic [DATA_W-1:0]   operand,
  output logic [DATA_W/2-1:0] root,
  output logic [DATA_W/2:0]   rem
);
  localparam int ROOT_W = DATA_W / 2;
  localparam int REM_W  = ROOT_W + 2;

  logic [DATA_W-1:0] d_q;
  logic [ROOT_W-1:0] q_q;
  logic [REM_W-1:0]  r_q;

  logic             neg;
  logic [REM_W-1:0] r_shift, iter_op, fix_op, add_a, add_b, add_sum;
  logic             add_sub;

  always_comb begin
    neg     = r_q[REM_W-1];
    r_shift = {r_q[REM_W-3:0], d_q[DATA_W-1 -: 2]};
    iter_op = {q_q, neg, 1'b1};
    fix_op  = {1'b0, q_q, 1'b1};
    add_a   = fix ? r_q    : r_shift;
    add_b   = fix ? fix_op : iter_op;
    add_sub = fix ? 1'b0   : !neg;
  end

  nrsqrt_addsub #(.W(REM_W)) u_addsub (
    .a   (add_a),
    .b   (add_b),
    .sub (add_sub),
    .sum (add_sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q <= '0;
      q_q <= '0;
      r_q <= '0;
    end else if (load) begin
      d_q <= operand;
      q_q <= '0;
      r_q <= '0;
    end else if (step) begin
      d_q <= {d_q[DATA_W-3:0], 2'b00};
      q_q <= {q_q[ROOT_W-2:0], ~add_sum[REM_W-1]};
      r_q <= add_sum;
    end else if (fix && neg) begin
      r_q <= add_sum;
    end
  end

  assign root = q_q;
  assign rem  = r_q[ROOT_W:0];

  assert_fix_nonneg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fix |=> !r_q[REM_W-1]);

  assert_operand_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (d_q[DATA_W-1:2] == $past(d_q[DATA_W-3:0])));
endmodule

// File: rtl/nrsqrt_unit.sv
module nrsqrt_unit #(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DATA_W-1:0]   in_operand,
  output logic                out_valid,
  output logic [DATA_W/2-1:0] out_root,
  output logic [DATA_W/2:0]   out_rem
);
  localparam int ROOT_W = DATA_W / 2;

  logic load, step, fix;

  nrsqrt_ctrl #(.ROOT_W(ROOT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .load      (load),
    .step      (step),
    .fix       (fix),
    .out_valid (out_valid)
  );

  nrsqrt_path #(.DATA_W(DATA_W)) u_path (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .step    (step),
    .fix     (fix),
    .operand (in_operand),
    .root    (out_root),
    .rem     (out_rem)
  );

  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_ready) && !$past(in_valid)) |-> ($stable(out_root) && $stable(out_rem)));

  assert_rem_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_rem <= {out_root, 1'b0}));
endmodule

// File: tb/nrsqrt_unit_test.sv
`timescale 1ns/1ps
module nrsqrt_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_operand = '0;
  logic        out_valid;
  logic [15:0] out_root;
  logic [16:0] out_rem;

  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk;

  nrsqrt_unit #(.DATA_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .out_valid(out_valid),
    .out_root(out_root), .out_rem(out_rem)
  );

  function automatic longint unsigned ref_root(longint unsigned v);
    longint unsigned r = 0;
    for (int b = 15; b >= 0; b--) begin
      longint unsigned t = r | (64'd1 << b);
      if (t * t <= v) r = t;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input longint unsigned act, input longint unsigned exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge where out_valid was seen.
  task automatic run_op(input logic [31:0] x, input bit poke);
    longint unsigned er, em;
    int lat = -1;
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_operand = x;
    @(negedge clk);
    in_valid = 1'b0;
    in_operand = $urandom;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (poke && k == 5) begin
        in_valid = 1'b1;            // R1: offered while busy, must be ignored
        in_operand = ~x;
      end else begin
        in_valid = 1'b0;
      end
      if (k == 10) check(in_ready == 1'b0, "R1 ready low while busy", in_ready, 0);
      if (out_valid) begin lat = k; break; end
    end
    check(lat == 17, "R2 latency", lat, 17);
    check(in_ready == 1'b1, "R9 ready with done", in_ready, 1);
    er = ref_root(longint'(x));
    em = longint'(x) - er * er;
    check(out_root == er, "R3 R6 root", out_root, er);
    check(out_rem == em, "R4 R7 remainder", out_rem, em);
    check(longint'(out_rem) <= 2 * longint'(out_root), "R4 rem bound",
          out_rem, 2 * out_root);
    check(longint'(out_root) * longint'(out_root) + longint'(out_rem) == longint'(x),
          "R4 root^2+rem", longint'(out_root) * longint'(out_root) + longint'(out_rem), x);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [15:0] hr;
    logic [16:0] hm;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R8: reset state
    check(in_ready == 1'b1, "R8 ready in reset", in_ready, 1);
    check(out_valid == 1'b0, "R8 valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_root == 0, "R8 root after reset", out_root, 0);
    check(out_rem == 0, "R8 rem after reset", out_rem, 0);
    check(out_valid == 1'b0, "R8 no pulse after reset", out_valid, 0);

    // Directed corners
    run_op(32'd0, 1'b0);
    run_op(32'd1, 1'b0);
    run_op(32'd2, 1'b0);
    run_op(32'd3, 1'b0);
    run_op(32'd4, 1'b0);
    run_op(32'hFFFF_FFFF, 1'b0);
    run_op(32'hFFFE_0001, 1'b0);
    run_op(32'hFFFE_0000, 1'b0);
    run_op(32'h4000_0000, 1'b0);
    run_op(32'h3FFF_FFFF, 1'b1);   // R1: busy offer ignored

    // R5: outputs held while idle
    hr = out_root;
    hm = out_rem;
    @(negedge clk);
    in_operand = 32'h1234_5678;
    repeat (6) @(negedge clk);
    check(out_root == hr, "R5 root held", out_root, hr);
    check(out_rem == hm, "R5 rem held", out_rem, hm);
    check(out_valid == 1'b0, "R2 no extra pulse", out_valid, 0);

    // Random mix: squares, squares minus one, small values, full range
    for (int i = 0; i < 400; i++) begin
      logic [31:0] x;
      logic [15:0] s;
      s = $urandom;
      case ($urandom % 4)
        0: x = 32'(s) * 32'(s);
        1: x = 32'(s) * 32'(s) - 32'd1;
        2: x = $urandom % 300;
        default: x = $urandom;
      endcase
      run_op(x, ($urandom % 8) == 0);
      if (($urandom % 3) == 0) repeat ($urandom % 4) @(negedge clk);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule